// File: doc/BRIEF.md
# Banked Memory Crossbar with Connection Locking

This block joins a set of memory masters to a set of SDRAM bank machines. Each master raises a strobe with an address and a write flag; a field of that address names the bank machine that serves it. Each bank machine has its own round-robin arbiter. Once a bank machine has taken a request, it holds its `bLock` input high until every data acknowledgement it owes has been sent. While that input is high, the crossbar keeps the bank tied to the master that owns it, so data acknowledgements and read data can be steered back without tags.

A master may hold outstanding requests at only one bank machine at a time. This keeps completions in issue order for each master, while masters that use different banks still run in parallel. Write data needs no steering: idle masters drive zero, so the crossbar ORs all write buses into one. Read data reaches only the master that received the matching data acknowledgement, a fixed `RD_LAT` cycles after that acknowledgement.

Top module: `mem_xbar`

## Requirements
- R1: After reset, with no master strobing, every request ack, data ack, bank strobe, read data and write data output is zero.
- R2: A request goes to bank machine `adr[BANK_LSB +: log2(NB)]` only, with its address and write flag unchanged. `bStb` of a bank is high only for an address whose bank field equals that bank's index.
- R3: `mReqAck` of a master is high in exactly the cycle in which its target bank machine sees `bStb` and returns `bReqAck`. A master can be accepted again on the next cycle.
- R4: While `bLock` of a bank machine is high, only the master that owns it can be accepted there. Any other master that strobes that bank sees `mReqAck` low.
- R5: A master that owns a locked bank machine is not connected to any other bank machine, and its requests to those banks stall.
- R6: When a bank machine is unlocked, it grants the first eligible requester, searching upward with wraparound from the master after the one it last accepted. A master is eligible if it strobes that bank and owns no locked bank machine. After reset the search starts at master 0.
- R7: `bDatAck` of a bank machine appears in the same cycle on `mDatAck` of its owning master only. Each master receives its data acks in the order its requests were accepted.
- R8: Read data `bRdata` of a bank machine, presented `RD_LAT` cycles after a data ack, appears on `mRdata` of the acknowledged master in that cycle. Every other master sees zero.
- R9: `bWdata` is the bitwise OR of all master write buses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mAdr | input | NM*AW | Request address, one per master |
| mWe | input | NM | Write flag per master |
| mStb | input | NM | Request strobe per master |
| mWdata | input | NM*DW | Write data per master, zero when idle |
| mReqAck | output | NM | Request accepted, per master |
| mDatAck | output | NM | Data acknowledgement, per master |
| mRdata | output | NM*DW | Read data, per master |
| bAdr | output | NB*AW | Address per bank machine |
| bWe | output | NB | Write flag per bank machine |
| bStb | output | NB | Request strobe per bank machine |
| bWdata | output | DW | OR of all master write buses |
| bReqAck | input | NB | Request accepted by bank machine |
| bDatAck | input | NB | Data acknowledgement from bank machine |
| bLock | input | NB | Bank machine has queued requests |
| bRdata | input | NB*DW | Read data per bank machine |

## Verification
The hardest cases to reach are the stalls. In one, a master strobes a bank machine that is locked to another master. In the other, a master that owns one locked bank asks for a second bank while an unlocked bank has several eligible requesters at once. The stimulus first runs a contention phase in which every master targets bank 0 and the queue drains slowly, so the lock stays up and the other masters queue behind it. It then runs a long random phase in which the bench bank machines accept and drain with random delays. Round-robin winners, stalls and order are checked in every cycle against a model of lock ownership kept in the bench.

// File: rtl/mem_xbar_pkg.sv
`timescale 1ns/1ps
package mem_xbar_pkg;
  // Connection state a bank arbiter hands to the datapath.
  typedef struct packed {
    logic       conn;  // a master is connected to this bank
    logic [7:0] cur;   // master connected in this cycle
    logic [7:0] held;  // master owning the queued requests
  } routeT;
endpackage

// File: rtl/mem_xbar_ctrl.sv
`timescale 1ns/1ps
module mem_xbar_ctrl
  import mem_xbar_pkg::*;
#(
  parameter int NM = 3,
  parameter int NB = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NM-1:0]                mStb,
  input  logic [NM-1:0][$clog2(NB)-1:0] mBank,
  input  logic [NB-1:0]                bLock,
  input  logic [NB-1:0]                bStb,
  input  logic [NB-1:0]                bReqAck,
  output routeT [NB-1:0]               route
);
  localparam int BW = $clog2(NB);
  localparam int MW = $clog2(NM);

  logic [NB-1:0][MW-1:0] heldAll;
  logic [NM-1:0]         busy;

  // a master owning a locked bank may not be granted elsewhere
  always_comb begin
    busy = '0;
    for (int b = 0; b < NB; b++)
      for (int m = 0; m < NM; m++)
        if (bLock[b] && heldAll[b] == MW'(m)) busy[m] = 1'b1;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [MW-1:0] heldR, rrPtr, pick, winner;
    logic          found;
    routeT         r;

    always_comb begin
      pick  = heldR;
      found = 1'b0;
      for (int k = 0; k < NM; k++) begin
        int            j;
        logic [MW-1:0] jj;
        j = int'(rrPtr) + k;
        if (j >= NM) j = j - NM;
        jj = MW'(j);
        if (!found && mStb[jj] && mBank[jj] == BW'(b) && !busy[jj]) begin
          found = 1'b1;
          pick  = jj;
        end
      end
      winner = bLock[b] ? heldR : pick;
      r.conn = bLock[b] | found;
      r.cur  = 8'(winner);
      r.held = 8'(heldR);
    end

    assign route[b]   = r;
    assign heldAll[b] = heldR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        heldR <= '0;
        rrPtr <= '0;
      end else begin
        if (!bLock[b] && found) heldR <= pick;
        if (bStb[b] && bReqAck[b])
          rrPtr <= (winner == MW'(NM - 1)) ? '0 : winner + MW'(1);
      end
    end
  end
endmodule

// File: rtl/mem_xbar_dp.sv
`timescale 1ns/1ps
module mem_xbar_dp
  import mem_xbar_pkg::*;
#(
  parameter int NM       = 3,
  parameter int NB       = 4,
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int BANK_LSB = 3,
  parameter int RD_LAT   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NM-1:0][AW-1:0]         mAdr,
  input  logic [NM-1:0]                 mWe,
  input  logic [NM-1:0]                 mStb,
  input  logic [NM-1:0][DW-1:0]         mWdata,
  input  routeT [NB-1:0]                route,
  input  logic [NB-1:0]                 bReqAck,
  input  logic [NB-1:0]                 bDatAck,
  input  logic [NB-1:0][DW-1:0]         bRdata,
  output logic [NM-1:0][$clog2(NB)-1:0] mBank,
  output logic [NB-1:0][AW-1:0]         bAdr,
  output logic [NB-1:0]                 bWe,
  output logic [NB-1:0]                 bStb,
  output logic [DW-1:0]                 bWdata,
  output logic [NM-1:0]                 mReqAck,
  output logic [NM-1:0]                 mDatAck,
  output logic [NM-1:0][DW-1:0]         mRdata
);
  localparam int BW = $clog2(NB);

  logic [NB-1:0][NM-1:0] curHot, heldHot, rdHot;

  for (genvar m = 0; m < NM; m++) begin : g_mst
    assign mBank[m] = mAdr[m][BANK_LSB +: BW];
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [RD_LAT-1:0][NM-1:0] ownPipe;

    always_comb begin
      bAdr[b] = '0;
      bWe[b]  = 1'b0;
      bStb[b] = 1'b0;
      for (int m = 0; m < NM; m++) begin
        curHot[b][m]  = route[b].cur == 8'(m);
        heldHot[b][m] = route[b].held == 8'(m);
        if (curHot[b][m]) begin
          bAdr[b] = mAdr[m];
          bWe[b]  = mWe[m];
          bStb[b] = route[b].conn && mStb[m] && mBank[m] == BW'(b);
        end
      end
    end

    // one-hot owner travels with each data ack for RD_LAT cycles
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ownPipe <= '0;
      end else begin
        ownPipe[0] <= bDatAck[b] ? heldHot[b] : '0;
        for (int s = 1; s < RD_LAT; s++) ownPipe[s] <= ownPipe[s-1];
      end
    end
    assign rdHot[b] = ownPipe[RD_LAT-1];
  end

  always_comb begin
    mReqAck = '0;
    mDatAck = '0;
    mRdata  = '0;
    bWdata  = '0;
    for (int m = 0; m < NM; m++) begin
      bWdata = bWdata | mWdata[m];
      for (int b = 0; b < NB; b++) begin
        if (bStb[b] && bReqAck[b] && curHot[b][m]) mReqAck[m] = 1'b1;
        if (bDatAck[b] && heldHot[b][m])           mDatAck[m] = 1'b1;
        if (rdHot[b][m]) mRdata[m] = mRdata[m] | bRdata[b];
      end
    end
  end
endmodule

// File: rtl/mem_xbar.sv
`timescale 1ns/1ps
module mem_xbar
  import mem_xbar_pkg::*;
#(
  parameter int NM       = 3,
  parameter int NB       = 4,
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int BANK_LSB = 3,
  parameter int RD_LAT   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NM-1:0][AW-1:0] mAdr,
  input  logic [NM-1:0]         mWe,
  input  logic [NM-1:0]         mStb,
  input  logic [NM-1:0][DW-1:0] mWdata,
  output logic [NM-1:0]         mReqAck,
  output logic [NM-1:0]         mDatAck,
  output logic [NM-1:0][DW-1:0] mRdata,
  output logic [NB-1:0][AW-1:0] bAdr,
  output logic [NB-1:0]         bWe,
  output logic [NB-1:0]         bStb,
  output logic [DW-1:0]         bWdata,
  input  logic [NB-1:0]         bReqAck,
  input  logic [NB-1:0]         bDatAck,
  input  logic [NB-1:0]         bLock,
  input  logic [NB-1:0][DW-1:0] bRdata
);
  routeT [NB-1:0]                 route;
  logic  [NM-1:0][$clog2(NB)-1:0] mBank;

  mem_xbar_ctrl #(.NM(NM), .NB(NB)) ctrl_i (
    .clk(clk), .rstN(rstN), .mStb(mStb), .mBank(mBank),
    .bLock(bLock), .bStb(bStb), .bReqAck(bReqAck), .route(route)
  );

  mem_xbar_dp #(
    .NM(NM), .NB(NB), .AW(AW), .DW(DW), .BANK_LSB(BANK_LSB), .RD_LAT(RD_LAT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .mAdr(mAdr), .mWe(mWe), .mStb(mStb),
    .mWdata(mWdata), .route(route), .bReqAck(bReqAck), .bDatAck(bDatAck),
    .bRdata(bRdata), .mBank(mBank), .bAdr(bAdr), .bWe(bWe), .bStb(bStb),
    .bWdata(bWdata), .mReqAck(mReqAck), .mDatAck(mDatAck), .mRdata(mRdata)
  );
endmodule

// File: rtl/mem_xbar_chk.sv
`timescale 1ns/1ps
module mem_xbar_chk
  import mem_xbar_pkg::*;
#(
  parameter int NM       = 3,
  parameter int NB       = 4,
  parameter int AW       = 12,
  parameter int BANK_LSB = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NM-1:0]         mStb,
  input logic [NM-1:0]         mReqAck,
  input logic [NM-1:0]         mDatAck,
  input logic [NB-1:0][AW-1:0] bAdr,
  input logic [NB-1:0]         bStb,
  input logic [NB-1:0]         bLock,
  input logic [NB-1:0]         bDatAck,
  input routeT [NB-1:0]        route
);
  logic [NB-1:0] ownedBy [NM];

  always_comb
    for (int m = 0; m < NM; m++)
      for (int b = 0; b < NB; b++)
        ownedBy[m][b] = bLock[b] && route[b].held == 8'(m);

  for (genvar b = 0; b < NB; b++) begin : g_b
    // R2
    bank_field_chk: assert property (@(posedge clk) disable iff (!rstN)
      bStb[b] |-> (((bAdr[b] >> BANK_LSB) & AW'(NB - 1)) == AW'(b)));
    // R4
    owner_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
      (bLock[b] && $past(bLock[b])) |-> route[b].held == $past(route[b].held));
  end

  for (genvar m = 0; m < NM; m++) begin : g_m
    // R3
    req_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
      mReqAck[m] |-> mStb[m]);
    // R5
    single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
      $countones(ownedBy[m]) <= 1);
  end

  // R7
  dat_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mDatAck != '0) |-> (bDatAck != '0));
endmodule

bind mem_xbar mem_xbar_chk #(
  .NM(NM), .NB(NB), .AW(AW), .BANK_LSB(BANK_LSB)
) chk_i (
  .clk(clk), .rstN(rstN), .mStb(mStb), .mReqAck(mReqAck), .mDatAck(mDatAck),
  .bAdr(bAdr), .bStb(bStb), .bLock(bLock), .bDatAck(bDatAck), .route(route)
);

// File: tb/mem_xbar_tb.sv
`timescale 1ns/1ps
module mem_xbar_tb_top;
  localparam int NM = 3, NB = 4, AW = 12, DW = 16, BANK_LSB = 3;
  localparam int RD_LAT = 2, WR_LAT = 3, QD = 4;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0, rstN = 1'b0;
  logic [NM-1:0][AW-1:0] mAdr = '0;
  logic [NM-1:0] mWe = '0, mStb = '0;
  logic [NM-1:0][DW-1:0] mWdata = '0;
  logic [NM-1:0] mReqAck, mDatAck;
  logic [NM-1:0][DW-1:0] mRdata;
  logic [NB-1:0][AW-1:0] bAdr;
  logic [NB-1:0] bWe, bStb, bReqAck;
  logic [DW-1:0] bWdata;
  logic [NB-1:0] bDatAck = '0, bLock = '0, bReady = '0;
  logic [NB-1:0][DW-1:0] bRdata = '0;

  assign bReqAck = bStb & bReady;

  mem_xbar #(.NM(NM), .NB(NB), .AW(AW), .DW(DW), .BANK_LSB(BANK_LSB),
             .RD_LAT(RD_LAT)) dut_i (.*);

  always #2.5 clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0;
  bit done = 0;
  int bqAdr[NB][$]; bit bqWe[NB][$]; int bqMid[NB][$];
  int mqAdr[NM][$];
  int bOwner[NB], rrNext[NB];
  int rdAdr[NM][8], wrAdr[NM][8], brAdr[NB][8];
  bit rdV[NM][8], wrV[NM][8], brV[NB][8], clr[NM];

  function automatic logic [DW-1:0] rdVal(int a);
    return DW'(a * 7 + 'h1234) | DW'(1);
  endfunction
  function automatic logic [DW-1:0] wrVal(int m, int a);
    return DW'(a * 13 + m * 'h1000 + 'h21) | DW'(1);
  endfunction
  function automatic int tgt(int m);
    return int'(mAdr[m][BANK_LSB +: BW]);
  endfunction
  function automatic bit busyOther(int m, int b);
    for (int c = 0; c < NB; c++)
      if (c != b && bLock[c] && bOwner[c] == m) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  task automatic drive(bit focus, bit issue);
    int slot = cyc % 8;
    for (int b = 0; b < NB; b++) begin
      bRdata[b]  = brV[b][slot] ? rdVal(brAdr[b][slot]) : '0;
      bLock[b]   = bqAdr[b].size() > 0;
      bReady[b]  = (bqAdr[b].size() < QD) && (focus || $urandom % 4 != 0);
      bDatAck[b] = (bqAdr[b].size() > 0) && ($urandom % (focus ? 4 : 3) == 0);
    end
    for (int m = 0; m < NM; m++) begin
      logic [AW-1:0] a;
      mWdata[m] = wrV[m][slot] ? wrVal(m, wrAdr[m][slot]) : '0;
      if (clr[m]) begin mStb[m] = 0; clr[m] = 0; end
      if (!mStb[m] && issue && $urandom % 3 != 0) begin
        a = AW'($urandom);
        a[BANK_LSB +: BW] = focus ? '0 : BW'($urandom % NB);
        mAdr[m] = a; mWe[m] = $urandom % 2 == 1; mStb[m] = 1;
      end
    end
  endtask

  task automatic sample();
    int slot = cyc % 8;
    logic [DW-1:0] orExp = '0;
    logic [NM-1:0] datExp = '0;
    // R8 read data steering, R9 write OR
    for (int m = 0; m < NM; m++) begin
      logic [DW-1:0] e = rdV[m][slot] ? rdVal(rdAdr[m][slot]) : '0;
      chk(mRdata[m] == e, "R8 rdata", mRdata[m], e);
      if (wrV[m][slot]) orExp |= wrVal(m, wrAdr[m][slot]);
      rdV[m][slot] = 0; wrV[m][slot] = 0;
    end
    chk(bWdata == orExp, "R9 wdata", bWdata, orExp);
    for (int b = 0; b < NB; b++) brV[b][slot] = 0;
    // stalls: R4 and R5
    for (int m = 0; m < NM; m++) if (mStb[m]) begin
      int b = tgt(m);
      if (bLock[b] && bOwner[b] != m) chk(!mReqAck[m], "R4 stall", mReqAck[m], 0);
      if (busyOther(m, b)) chk(!mReqAck[m], "R5 stall", mReqAck[m], 0);
      if (mReqAck[m]) chk(bStb[b] && bReqAck[b], "R3 ack pairing", bStb[b], 1);
    end
    // data acks, R7
    for (int b = 0; b < NB; b++) if (bDatAck[b]) begin
      int a = bqAdr[b].pop_front(); bit w = bqWe[b].pop_front();
      int id = bqMid[b].pop_front(); int h = mqAdr[id].pop_front();
      datExp[id] = 1;
      chk(h == a, "R7 order", a, h);
      if (w) begin wrV[id][(cyc + WR_LAT) % 8] = 1; wrAdr[id][(cyc + WR_LAT) % 8] = a; end
      else begin
        rdV[id][(cyc + RD_LAT) % 8] = 1; rdAdr[id][(cyc + RD_LAT) % 8] = a;
        brV[b][(cyc + RD_LAT) % 8] = 1;  brAdr[b][(cyc + RD_LAT) % 8] = a;
      end
    end
    chk(mDatAck == datExp, "R7 dat ack", mDatAck, datExp);
    // request side, R2 R3 R4 R6
    for (int b = 0; b < NB; b++) begin
      if (bStb[b]) chk(int'(bAdr[b][BANK_LSB +: BW]) == b, "R2 bank field", bAdr[b], b);
      if (bStb[b] && bReqAck[b]) begin
        int n = 0, w = -1, pick = -1;
        for (int m = 0; m < NM; m++) if (mReqAck[m] && tgt(m) == b) begin n++; w = m; end
        chk(n == 1, "R3 single ack", n, 1);
        if (n == 1) begin
          chk(bAdr[b] == mAdr[w] && bWe[b] == mWe[w], "R2 fields", bAdr[b], mAdr[w]);
          if (bLock[b]) chk(w == bOwner[b], "R4 owner", w, bOwner[b]);
          else begin
            for (int k = 0; k < NM && pick < 0; k++) begin
              int j = (rrNext[b] + k) % NM;
              if (mStb[j] && tgt(j) == b && !busyOther(j, b)) pick = j;
            end
            chk(w == pick, "R6 round robin", w, pick);
          end
          bqAdr[b].push_back(int'(bAdr[b])); bqWe[b].push_back(bWe[b]);
          bqMid[b].push_back(w); mqAdr[w].push_back(int'(bAdr[b]));
          bOwner[b] = w; rrNext[b] = (w + 1) % NM; clr[w] = 1;
        end
      end
    end
  endtask

  task automatic run(int n, bit focus, bit issue);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); drive(focus, issue);
      #2; sample(); cyc++;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int b = 0; b < NB; b++) begin bOwner[b] = 0; rrNext[b] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    #2;
    // R1 reset state
    chk(mReqAck == '0 && mDatAck == '0, "R1 acks", {mReqAck, mDatAck}, 0);
    chk(mRdata == '0, "R1 rdata", mRdata[0], 0);
    chk(bStb == '0 && bWdata == '0, "R1 bank side", bWdata, 0);
    run(400, 1, 1);   // contention on bank 0
    run(3000, 0, 1);  // random traffic
    run(60, 0, 0);    // drain
    for (int m = 0; m < NM; m++) chk(mqAdr[m].size() == 0, "R7 drained", mqAdr[m].size(), 0);
    finish_run();
  end

  initial begin
    #300000;
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule